// File: doc/BRIEF.md
# Stack Pointer with Limit Trap

This block keeps the pointer of an upward-growing word stack together with a programmable upper bound, and turns push, pop, call and exception-entry requests into memory effective addresses and write data. Each request is examined for a stack fault in the same cycle. A fault cancels the memory access, leaves the pointer where it was, and produces a one-cycle trap pulse on the following cycle.

The pointer always names the next free word. A push stores there and then advances by 2. A pop steps back by 2 and then reads. A call or an exception entry stores a two-word return frame through two write lanes in one cycle. The lower word is the low half of the program counter. The upper word carries the program counter's top seven bits, and on exception entry it also carries an eight-bit status byte. Software loads the pointer and the bound through two write ports. The bound has no reset value, so bound checking stays off until the bound has been loaded once.

Top module: `stack_guard`

## Requirements
- R1: A push (op code 1) drives write lane 0 with address equal to the pointer and data equal to `push_data_i`. The pointer reads 2 higher after the clock edge.
- R2: A pop (op code 2) drives the read enable with address pointer−2 and drives no write. The pointer reads 2 lower after the edge.
- R3: A call (op code 3) drives lane 0 with address pointer and data PC[15:0], and lane 1 with address pointer+2 and data {9'b0, PC[22:16]}. The pointer reads 4 higher after the edge.
- R4: An exception entry (op code 4) writes the same addresses and lane-0 data as a call. Lane 1 carries {status[7:0], 1'b0, PC[22:16]}. The pointer advances by 4.
- R5: Bit 0 is cleared in every value written to the pointer or to the bound.
- R6: Once the bound is loaded, a request whose highest written address (pointer for a push, pointer+2 for a frame) exceeds the bound raises the overflow trap. An address equal to the bound is allowed.
- R7: A write at an address below 0x0800, or a pop whose read address would fall below 0x0800, raises the underflow trap.
- R8: A faulting request drives no write enable and no read enable, and leaves the pointer unchanged. Its trap output is high for exactly the one cycle after the request.
- R9: A bound write takes effect from the next cycle. A request in the same cycle is checked against the old bound.
- R10: Reset sets the pointer to 0x0800, clears both traps, and disables overflow checking until the bound is first written.
- R11: A pointer write in the same cycle as a request takes priority for the pointer's next value. The request's addresses and checks use the old pointer.
- R12: Op codes 0 and 5 to 7 request nothing: no enable, no trap, and the pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Request: 0 none, 1 push, 2 pop, 3 call, 4 exception entry |
| push_data_i | input | 16 | Data word for a push |
| pc_i | input | 23 | Program counter stored in a frame |
| status_i | input | 8 | Status byte stored in an exception frame |
| sp_we_i | input | 1 | Load the pointer |
| sp_wdata_i | input | 16 | Value for the pointer (bit 0 ignored) |
| lim_we_i | input | 1 | Load the bound |
| lim_wdata_i | input | 16 | Value for the bound (bit 0 ignored) |
| wr0_en_o | output | 1 | Write lane 0 enable |
| wr0_addr_o | output | 16 | Write lane 0 address |
| wr0_data_o | output | 16 | Write lane 0 data |
| wr1_en_o | output | 1 | Write lane 1 enable (frames only) |
| wr1_addr_o | output | 16 | Write lane 1 address |
| wr1_data_o | output | 16 | Write lane 1 data |
| rd_en_o | output | 1 | Read enable for a pop |
| rd_addr_o | output | 16 | Read address for a pop |
| sp_o | output | 16 | Current pointer |
| ovf_trap_o | output | 1 | Overflow trap pulse |
| udf_trap_o | output | 1 | Underflow trap pulse |

## Verification
Lane enables, addresses, data and the read request depend only on the present request and the registered pointer and bound. They are due in the same cycle, and the bench samples them 1 ns before the rising edge that accepts the request. The pointer value and both trap pulses are due one edge later, and the bench samples them 1 ns after that edge. Trap pulses are one cycle long, so the vector that follows a faulting one checks that the flag has dropped. The same-cycle bound and pointer writes are driven together with a request, so the old-versus-new value rules are checked at exactly the edge where they matter.

// File: rtl/stack_guard_pkg.sv
// Package: shared request encoding for the stack guard.
// Assumes: op codes outside the listed values mean "no request".
package stack_guard_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_EXC  = 3'd4
    } sg_op_e;
endpackage

// File: rtl/sg_regs.sv
// Module: pointer and bound registers.
// Holds the word-aligned stack pointer, the bound, and a flag that records
// whether the bound has been loaded since reset. A software pointer write
// takes priority over the request's update. The bound has no reset value.
module sg_regs #(
    parameter int DW      = 16,
    parameter int RST_PTR = 'h0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sp_we,
    input  logic [DW-1:0] sp_wdata,
    input  logic          lim_we,
    input  logic [DW-1:0] lim_wdata,
    input  logic          adv_en,
    input  logic [DW-1:0] adv_next,
    output logic [DW-1:0] sp_q,
    output logic [DW-1:0] lim_q,
    output logic          lim_set_q
);
    localparam logic [DW-1:0] ALIGN_MASK = ~DW'(1);
    localparam logic [DW-1:0] RST_V      = DW'(RST_PTR);

    // Pointer: reset value, then software write, then request update.
    always_ff @(posedge clk) begin
        if (!rst_n)      sp_q <= RST_V;
        else if (sp_we)  sp_q <= sp_wdata & ALIGN_MASK;
        else if (adv_en) sp_q <= adv_next & ALIGN_MASK;
    end

    // Bound value: loaded only by software, no reset.
    always_ff @(posedge clk) begin
        if (lim_we) lim_q <= lim_wdata & ALIGN_MASK;
    end

    // Bound-loaded flag: cleared at reset, set by the first bound write.
    always_ff @(posedge clk) begin
        if (!rst_n)      lim_set_q <= 1'b0;
        else if (lim_we) lim_set_q <= 1'b1;
    end

    // R11
    sp_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |=> sp_q == ($past(sp_wdata) & ALIGN_MASK));
endmodule

// File: rtl/sg_check.sv
// Module: request classifier and fault checker.
// Combinational. From the request and the registered pointer and bound it
// gives the fault flags and the pointer value that would follow. Frame
// requests are checked at their upper word address.
module sg_check
    import stack_guard_pkg::*;
#(
    parameter int DW    = 16,
    parameter int FLOOR = 'h0800
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] lim,
    input  logic          lim_set,
    output logic          is_wr,
    output logic          is_frame,
    output logic          is_rd,
    output logic          ovf,
    output logic          udf,
    output logic [DW-1:0] next_sp
);
    localparam logic [DW-1:0] FLOOR_V   = DW'(FLOOR);
    localparam logic [DW-1:0] POP_MIN_V = DW'(FLOOR + 2);

    sg_op_e        op_e;
    logic [DW-1:0] top_ea;

    // Decode the request and evaluate both fault conditions.
    always_comb begin
        op_e     = sg_op_e'(op);
        is_frame = (op_e == OP_CALL) || (op_e == OP_EXC);
        is_wr    = (op_e == OP_PUSH) || is_frame;
        is_rd    = (op_e == OP_POP);
        top_ea   = is_frame ? sp + DW'(2) : sp;
        ovf      = is_wr && lim_set && (top_ea > lim);
        udf      = (is_wr && (sp < FLOOR_V)) || (is_rd && (sp < POP_MIN_V));
        if (is_rd)         next_sp = sp - DW'(2);
        else if (is_frame) next_sp = sp + DW'(4);
        else if (is_wr)    next_sp = sp + DW'(2);
        else               next_sp = sp;
    end
endmodule

// File: rtl/sg_frame.sv
// Module: write-data builder.
// Lane 0 carries the push word or the low program-counter half. Lane 1
// carries the upper program-counter bits, zero-extended for a call or
// packed under the status byte for an exception entry.
// Assumes: status plus one gap bit plus the upper PC bits fit one word.
module sg_frame #(
    parameter int DW  = 16,
    parameter int PCW = 23,
    parameter int STW = 8
) (
    input  logic           frame_sel,
    input  logic           exc_sel,
    input  logic [DW-1:0]  push_data,
    input  logic [PCW-1:0] pc,
    input  logic [STW-1:0] status,
    output logic [DW-1:0]  w0_data,
    output logic [DW-1:0]  w1_data
);
    localparam int PCHI = PCW - DW;
    localparam int GAP  = DW - STW - PCHI;

    logic [PCHI-1:0] pc_hi;
    logic [DW-1:0]   w1_call;
    logic [DW-1:0]   w1_exc;

    // Split the program counter.
    assign pc_hi = pc[PCW-1:DW];

    // Upper-word layouts; generate picks a packing legal for the widths.
    generate
        if (GAP >= 1) begin : g_fit
            assign w1_exc = {status, {GAP{1'b0}}, pc_hi};
        end else begin : g_nofit
            assign w1_exc = {{(DW-PCHI){1'b0}}, pc_hi};
        end
    endgenerate
    assign w1_call = {{(DW-PCHI){1'b0}}, pc_hi};

    // Choose each lane's data from the request kind.
    always_comb begin
        w0_data = frame_sel ? pc[DW-1:0] : push_data;
        w1_data = exc_sel ? w1_exc : w1_call;
    end
endmodule

// File: rtl/stack_guard.sv
// Module: stack pointer with bound and floor traps (top).
// Turns stack requests into memory addresses and data through two write
// lanes and one read port. A faulting request is cancelled and pulses its
// trap one cycle later.
// Assumes: memory takes both lanes in the cycle the enables are high.
module stack_guard
    import stack_guard_pkg::*;
#(
    parameter int DW      = 16,
    parameter int PCW     = 23,
    parameter int STW     = 8,
    parameter int FLOOR   = 'h0800,
    parameter int RST_PTR = 'h0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     op_i,
    input  logic [DW-1:0]  push_data_i,
    input  logic [PCW-1:0] pc_i,
    input  logic [STW-1:0] status_i,
    input  logic           sp_we_i,
    input  logic [DW-1:0]  sp_wdata_i,
    input  logic           lim_we_i,
    input  logic [DW-1:0]  lim_wdata_i,
    output logic           wr0_en_o,
    output logic [DW-1:0]  wr0_addr_o,
    output logic [DW-1:0]  wr0_data_o,
    output logic           wr1_en_o,
    output logic [DW-1:0]  wr1_addr_o,
    output logic [DW-1:0]  wr1_data_o,
    output logic           rd_en_o,
    output logic [DW-1:0]  rd_addr_o,
    output logic [DW-1:0]  sp_o,
    output logic           ovf_trap_o,
    output logic           udf_trap_o
);
    localparam logic [DW-1:0] FLOOR_V = DW'(FLOOR);

    logic [DW-1:0] sp_q, lim_q, next_sp;
    logic          lim_set_q;
    logic          is_wr, is_frame, is_rd, ovf_req, udf_req, fault;
    logic          adv_en;

    sg_regs #(.DW(DW), .RST_PTR(RST_PTR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sp_we(sp_we_i), .sp_wdata(sp_wdata_i),
        .lim_we(lim_we_i), .lim_wdata(lim_wdata_i),
        .adv_en(adv_en), .adv_next(next_sp),
        .sp_q(sp_q), .lim_q(lim_q), .lim_set_q(lim_set_q)
    );

    sg_check #(.DW(DW), .FLOOR(FLOOR)) u_check (
        .op(op_i), .sp(sp_q), .lim(lim_q), .lim_set(lim_set_q),
        .is_wr(is_wr), .is_frame(is_frame), .is_rd(is_rd),
        .ovf(ovf_req), .udf(udf_req), .next_sp(next_sp)
    );

    sg_frame #(.DW(DW), .PCW(PCW), .STW(STW)) u_frame (
        .frame_sel(is_frame), .exc_sel(sg_op_e'(op_i) == OP_EXC),
        .push_data(push_data_i), .pc(pc_i), .status(status_i),
        .w0_data(wr0_data_o), .w1_data(wr1_data_o)
    );

    // Gate the memory access with the fault decision.
    always_comb begin
        fault      = ovf_req || udf_req;
        wr0_en_o   = is_wr && !fault;
        wr1_en_o   = is_frame && !fault;
        rd_en_o    = is_rd && !fault;
        adv_en     = wr0_en_o || rd_en_o;
        wr0_addr_o = sp_q;
        wr1_addr_o = sp_q + DW'(2);
        rd_addr_o  = sp_q - DW'(2);
        sp_o       = sp_q;
    end

    // Register the fault flags into one-cycle trap pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_trap_o <= 1'b0;
            udf_trap_o <= 1'b0;
        end else begin
            ovf_trap_o <= ovf_req;
            udf_trap_o <= udf_req;
        end
    end

    // R1
    push_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sg_op_e'(op_i) == OP_PUSH && wr0_en_o && !sp_we_i) |=> sp_o == $past(sp_o) + DW'(2));
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1_en_o && lim_set_q) |-> wr1_addr_o <= lim_q);
    // R7
    floor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr0_en_o |-> wr0_addr_o >= FLOOR_V);
    // R7
    floor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> rd_addr_o >= FLOOR_V);
    // R8
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trap_o || udf_trap_o) && !$past(sp_we_i) |-> sp_o == $past(sp_o));
    // R10
    ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap_o |-> $past(lim_set_q));
endmodule

// File: tb/stack_guard_tb.sv
// Bench: vector table walked by one loop, then directed corner cases.
module stack_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [15:0] push_data_i = '0;
    logic [22:0] pc_i = '0;
    logic [7:0]  status_i = '0;
    logic        sp_we_i = 1'b0;
    logic [15:0] sp_wdata_i = '0;
    logic        lim_we_i = 1'b0;
    logic [15:0] lim_wdata_i = '0;
    logic        wr0_en_o, wr1_en_o, rd_en_o, ovf_trap_o, udf_trap_o;
    logic [15:0] wr0_addr_o, wr0_data_o, wr1_addr_o, wr1_data_o, rd_addr_o, sp_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stack_guard u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .push_data_i(push_data_i),
        .pc_i(pc_i), .status_i(status_i), .sp_we_i(sp_we_i),
        .sp_wdata_i(sp_wdata_i), .lim_we_i(lim_we_i), .lim_wdata_i(lim_wdata_i),
        .wr0_en_o(wr0_en_o), .wr0_addr_o(wr0_addr_o), .wr0_data_o(wr0_data_o),
        .wr1_en_o(wr1_en_o), .wr1_addr_o(wr1_addr_o), .wr1_data_o(wr1_data_o),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .sp_o(sp_o),
        .ovf_trap_o(ovf_trap_o), .udf_trap_o(udf_trap_o)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] din;
        logic [22:0] pc;
        logic [7:0]  st;
        logic        w0en;
        logic [15:0] w0a;
        logic [15:0] w0d;
        logic        w1en;
        logic [15:0] w1d;
        logic        rden;
        logic [15:0] rda;
        logic        ovf;
        logic        udf;
        logic [15:0] spx;
    } vec_t;

    // Bound 0x080A, pointer 0x0800 on entry.
    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{3'd1, 16'hAAAA, 23'h0, 8'h0, 1'b1, 16'h0800, 16'hAAAA, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0802},
        '{3'd1, 16'h1234, 23'h0, 8'h0, 1'b1, 16'h0802, 16'h1234, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0804},
        '{3'd3, 16'h0, 23'h7ABCDE, 8'h0, 1'b1, 16'h0804, 16'hBCDE, 1'b1, 16'h007A, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0808},
        '{3'd1, 16'h5555, 23'h0, 8'h0, 1'b1, 16'h0808, 16'h5555, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h080A},
        '{3'd1, 16'h6666, 23'h0, 8'h0, 1'b1, 16'h080A, 16'h6666, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h080C},
        '{3'd1, 16'h7777, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h080C},
        '{3'd2, 16'h0, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h080A, 1'b0, 1'b0, 16'h080A},
        '{3'd2, 16'h0, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0808, 1'b0, 1'b0, 16'h0808},
        '{3'd4, 16'h0, 23'h1F0042, 8'hC3, 1'b1, 16'h0808, 16'h0042, 1'b1, 16'hC31F, 1'b0, 16'h0, 1'b0, 1'b0, 16'h080C},
        '{3'd2, 16'h0, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h080A, 1'b0, 1'b0, 16'h080A},
        '{3'd2, 16'h0, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0808, 1'b0, 1'b0, 16'h0808},
        '{3'd2, 16'h0, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0806, 1'b0, 1'b0, 16'h0806},
        '{3'd2, 16'h0, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0804, 1'b0, 1'b0, 16'h0804},
        '{3'd2, 16'h0, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0802, 1'b0, 1'b0, 16'h0802},
        '{3'd2, 16'h0, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0800, 1'b0, 1'b0, 16'h0800},
        '{3'd2, 16'h0, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, 16'h0800},
        '{3'd7, 16'h9999, 23'h0, 8'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0800},
        '{3'd4, 16'h0, 23'h000001, 8'h00, 1'b1, 16'h0800, 16'h0001, 1'b1, 16'h0000, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0804},
        '{3'd3, 16'h0, 23'h7FFFFF, 8'hFF, 1'b1, 16'h0804, 16'hFFFF, 1'b1, 16'h007F, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0808}
    };

    // Compare one value and record the result.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs at the falling edge; returns 1 ns later.
    task automatic drive(input logic [2:0] op, input logic [15:0] din, input logic [22:0] pc,
                         input logic [7:0] st, input logic spwe, input logic [15:0] spd,
                         input logic lwe, input logic [15:0] ld);
        @(negedge clk);
        op_i = op; push_data_i = din; pc_i = pc; status_i = st;
        sp_we_i = spwe; sp_wdata_i = spd; lim_we_i = lwe; lim_wdata_i = ld;
        #1;
    endtask

    // Pass the rising edge, settle, then return inputs to idle.
    task automatic tick();
        @(posedge clk);
        #1;
        op_i = 3'd0; sp_we_i = 1'b0; lim_we_i = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 sp reset", sp_o, 16'h0800);
        chk("R10 ovf reset", ovf_trap_o, 0);
        chk("R10 udf reset", udf_trap_o, 0);
        chk("R10 no write", wr0_en_o, 0);

        // R10 bound not loaded: a high push does not trap
        drive(3'd0, 0, 0, 0, 1'b1, 16'hF000, 1'b0, 0); tick();
        drive(3'd1, 16'h0101, 0, 0, 1'b0, 0, 1'b0, 0);
        chk("R10 unbounded push en", wr0_en_o, 1);
        tick();
        chk("R10 unbounded no ovf", ovf_trap_o, 0);
        chk("R10 unbounded sp", sp_o, 16'hF002);

        // R5 bit 0 cleared on bound and pointer loads
        drive(3'd0, 0, 0, 0, 1'b1, 16'h0801, 1'b1, 16'h080B); tick();
        chk("R5 sp aligned", sp_o, 16'h0800);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].op, TBL[i].din, TBL[i].pc, TBL[i].st, 1'b0, 0, 1'b0, 0);
            chk($sformatf("R1-vec%0d wr0_en", i), wr0_en_o, TBL[i].w0en);
            if (TBL[i].w0en) begin
                chk($sformatf("R1 vec%0d wr0_addr", i), wr0_addr_o, TBL[i].w0a);
                chk($sformatf("R3 vec%0d wr0_data", i), wr0_data_o, TBL[i].w0d);
            end
            chk($sformatf("R3 vec%0d wr1_en", i), wr1_en_o, TBL[i].w1en);
            if (TBL[i].w1en) begin
                chk($sformatf("R3 vec%0d wr1_addr", i), wr1_addr_o, TBL[i].w0a + 16'd2);
                chk($sformatf("R4 vec%0d wr1_data", i), wr1_data_o, TBL[i].w1d);
            end
            chk($sformatf("R2 vec%0d rd_en", i), rd_en_o, TBL[i].rden);
            if (TBL[i].rden) chk($sformatf("R2 vec%0d rd_addr", i), rd_addr_o, TBL[i].rda);
            tick();
            chk($sformatf("R6 vec%0d ovf", i), ovf_trap_o, TBL[i].ovf);
            chk($sformatf("R7 vec%0d udf", i), udf_trap_o, TBL[i].udf);
            chk($sformatf("R8 R12 vec%0d sp", i), sp_o, TBL[i].spx);
        end

        // R6 frame whose upper word lands on the bound is allowed
        drive(3'd0, 0, 0, 0, 1'b1, 16'h0809, 1'b0, 0); tick();
        chk("R5 sp load aligned", sp_o, 16'h0808);
        drive(3'd3, 0, 23'h000010, 0, 1'b0, 0, 1'b0, 0);
        chk("R6 frame at bound wr1_en", wr1_en_o, 1);
        tick();
        chk("R6 frame at bound no ovf", ovf_trap_o, 0);
        // R6 frame one word past the bound traps, both lanes off
        drive(3'd0, 0, 0, 0, 1'b1, 16'h080A, 1'b0, 0); tick();
        drive(3'd4, 0, 23'h000010, 8'h11, 1'b0, 0, 1'b0, 0);
        chk("R8 frame ovf wr0_en", wr0_en_o, 0);
        chk("R8 frame ovf wr1_en", wr1_en_o, 0);
        tick();
        chk("R6 frame ovf", ovf_trap_o, 1);
        chk("R8 frame ovf sp", sp_o, 16'h080A);
        drive(3'd0, 0, 0, 0, 1'b0, 0, 1'b0, 0); tick();
        chk("R8 pulse ends", ovf_trap_o, 0);

        // R9 same-cycle bound write uses the old bound
        drive(3'd0, 0, 0, 0, 1'b1, 16'h0900, 1'b0, 0); tick();
        drive(3'd1, 16'h4444, 0, 0, 1'b0, 0, 1'b1, 16'h0900);
        chk("R9 old bound blocks write", wr0_en_o, 0);
        tick();
        chk("R9 old bound ovf", ovf_trap_o, 1);
        drive(3'd1, 16'h4444, 0, 0, 1'b0, 0, 1'b0, 0);
        chk("R9 new bound allows write", wr0_en_o, 1);
        tick();
        chk("R9 new bound no ovf", ovf_trap_o, 0);
        chk("R9 sp", sp_o, 16'h0902);

        // R11 pointer write beats the pop's update; pop uses old pointer
        drive(3'd2, 0, 0, 0, 1'b1, 16'h0A00, 1'b0, 0);
        chk("R11 rd_addr old sp", rd_addr_o, 16'h0900);
        tick();
        chk("R11 sp written", sp_o, 16'h0A00);

        // R7 push and frame below the floor
        drive(3'd0, 0, 0, 0, 1'b1, 16'h07FE, 1'b0, 0); tick();
        drive(3'd1, 16'h2222, 0, 0, 1'b0, 0, 1'b0, 0);
        chk("R7 push below floor wr0_en", wr0_en_o, 0);
        tick();
        chk("R7 push udf", udf_trap_o, 1);
        chk("R7 push sp held", sp_o, 16'h07FE);
        drive(3'd4, 0, 23'h1, 8'h1, 1'b0, 0, 1'b0, 0);
        chk("R7 exc below floor wr1_en", wr1_en_o, 0);
        tick();
        chk("R7 exc udf", udf_trap_o, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule